// File: doc/BRIEF.md
# Flash Access Timing Sequencer

This block times a single read of an on-chip flash array. A request carrying an address is accepted when the block is ready. For an ordinary access the block then emits two control pulses towards the array: an address-change pulse, and after a programmable hold gap a sense-equalise pulse. Both pulses, and the gap between them, have half-clock resolution. The block then waits a programmable number of whole cycles, captures the array's read data and pulses a done strobe.

When page mode is on and the new address lies in the same page as the previous access, the block skips both pulses. It waits a separate, shorter count and then returns the data. An active-low access-enable strobe is low for the whole access. Between accesses it must stay high for a programmed minimum, and the ready output holds new requests off until that time has elapsed.

All timing comes from one 32-bit configuration word that is written through byte lanes and can be read back. The hold-gap field normally follows the address-pulse field on every write that touches it. A lock bit breaks that link.

Top module: `flash_seq`

## Requirements
- R1: After reset the configuration reads `0x3F7F70F0`: rest select 3, wait 15, address-pulse length 7, equalise length 15, hold length 7, lock 0, page wait 15, page select 0. Bits outside mask `0x3F7F71F7` always read 0.
- R2: The address pulse (`addrPulse`) is high for (apLen+1) half cycles; apLen is bits [22:20].
- R3: From the fall of `addrPulse` to the rise of `eqPulse` there are (holdLen+1) half cycles; holdLen is bits [14:12]. The two pulses are never high together.
- R4: The equalise pulse is high for (eqLen+1) half cycles; eqLen is bits [19:16].
- R5: A normal access holds `flashEnN` low for ceil((apLen+holdLen+eqLen+3)/2) + waitLen + 1 cycles; waitLen is bits [27:24]. `respDone` is then high for exactly one cycle, and `respData` holds the array data for the accessed address.
- R6: On a page hit there is no pulse on either strobe, and `flashEnN` is low for pageWait+1 cycles; pageWait is bits [7:4].
- R7: With page select (bits [2:0]) equal to 0 no access is a page hit, even when the address repeats.
- R8: A write with byte lane 2 enabled (`cfgWrBe[2]`, bits [23:16]) also loads holdLen with the written apLen, provided the effective lock is 0. The effective lock is the written bit 8 when lane 1 is enabled, and the stored lock otherwise.
- R9: When the effective lock is 1, holdLen changes only through a lane-1 write of bits [14:12]. A later lane-1 write can set holdLen to a value that differs from apLen.
- R10: Between accesses `flashEnN` stays high for at least 5 cycles when rest select (bits [29:28]) is 3, and for at least 2 cycles otherwise. Under a constant request it stays high exactly that long.
- R11: `reqReady` is low from acceptance until the rest time has elapsed. A request presented while `reqReady` is low is ignored, and `flashAddr` changes only on acceptance.
- R12: A page hit requires a previous access and page select ≠ 0. The new address must also equal the previous one in every bit above the lowest pageSel+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used for the pulses |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrBe | input | 4 | Byte-lane enables of the write |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Current configuration word |
| reqValid | input | 1 | Access request |
| reqAddr | input | AW | Access address |
| reqReady | output | 1 | A request is accepted in this cycle |
| respDone | output | 1 | One-cycle strobe: read data valid |
| respData | output | DW | Captured read data |
| flashAddr | output | AW | Address presented to the array |
| flashData | input | DW | Read data from the array |
| addrPulse | output | 1 | Address-change pulse to the array |
| eqPulse | output | 1 | Sense-equalise pulse to the array |
| flashEnN | output | 1 | Access-enable strobe, low during an access |

## Verification
A table of configurations runs full accesses. The pulse widths and the gap are measured in nanoseconds, which separates odd from even half-cycle counts and shows whether the negative-edge half is placed correctly. The table also covers the hold field when it is copied and when it is locked. Repeated, neighbouring and far-away addresses under page selects 0, 1 and 3 separate a true page hit from a miss, from a hit wrongly taken with page mode off, and from a wrong offset width. Constant back-to-back requests under each rest setting expose the exact rest time. A request held during a busy access shows whether it leaks in.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam int REST_W  = 2;
  localparam int WAIT_W  = 4;
  localparam int AP_W    = 3;
  localparam int EQ_W    = 4;
  localparam int HOLD_W  = 3;
  localparam int PSEL_W  = 3;
  localparam int FIELD_MAX_W = 4;

  localparam int REST_LSB  = 28;
  localparam int WAIT_LSB  = 24;
  localparam int AP_LSB    = 20;
  localparam int EQ_LSB    = 16;
  localparam int HOLD_LSB  = 12;
  localparam int LOCK_BIT  = 8;
  localparam int PWAIT_LSB = 4;
  localparam int PSEL_LSB  = 0;
  localparam logic [31:0] RD_MASK = 32'h3F7F_71F7;

  localparam int MAX_HALF = (1 << AP_W) + (1 << HOLD_W) + (1 << EQ_W);
  localparam int HALF_W   = $clog2(MAX_HALF + 1);
  localparam int CYC_W    = HALF_W - 1;

  typedef struct packed {
    logic [REST_W-1:0] restSel;
    logic [WAIT_W-1:0] waitLen;
    logic [AP_W-1:0]   apLen;
    logic [EQ_W-1:0]   eqLen;
    logic [HOLD_W-1:0] holdLen;
    logic              holdLock;
    logic [WAIT_W-1:0] pageWait;
    logic [PSEL_W-1:0] pageSel;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{restSel: 2'd3, waitLen: 4'd15, apLen: 3'd7,
                                 eqLen: 4'd15, holdLen: 3'd7, holdLock: 1'b0,
                                 pageWait: 4'd15, pageSel: 3'd0};

  typedef struct packed {
    logic             accept;
    logic             capture;
    logic             inPulse;
    logic [CYC_W-1:0] cyc;
  } strobe_t;

  function automatic logic [HALF_W-1:0] halves(input logic [FIELD_MAX_W-1:0] f);
    return HALF_W'(f) + HALF_W'(1);
  endfunction
endpackage

// File: rtl/flash_seq_cfg.sv
`timescale 1ns/1ps
module flash_seq_cfg
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  output cfg_t        cfg,
  output logic [31:0] rdData
);
  logic effLock;
  logic unusedRes;

  assign effLock   = wrBe[1] ? wrData[LOCK_BIT] : cfg.holdLock;
  assign unusedRes = ^{wrData[31:30], wrData[23], wrData[15], wrData[11:9], wrData[3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET;
    end else if (wrEn) begin
      if (wrBe[3]) begin
        cfg.restSel <= wrData[REST_LSB +: REST_W];
        cfg.waitLen <= wrData[WAIT_LSB +: WAIT_W];
      end
      if (wrBe[2]) begin
        cfg.apLen <= wrData[AP_LSB +: AP_W];
        cfg.eqLen <= wrData[EQ_LSB +: EQ_W];
      end
      if (wrBe[1]) cfg.holdLock <= wrData[LOCK_BIT];
      if (wrBe[2] && !effLock) cfg.holdLen <= wrData[AP_LSB +: AP_W];
      else if (wrBe[1])        cfg.holdLen <= wrData[HOLD_LSB +: HOLD_W];
      if (wrBe[0]) begin
        cfg.pageWait <= wrData[PWAIT_LSB +: WAIT_W];
        cfg.pageSel  <= wrData[PSEL_LSB +: PSEL_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    rdData[REST_LSB +: REST_W]  = cfg.restSel;
    rdData[WAIT_LSB +: WAIT_W]  = cfg.waitLen;
    rdData[AP_LSB +: AP_W]      = cfg.apLen;
    rdData[EQ_LSB +: EQ_W]      = cfg.eqLen;
    rdData[HOLD_LSB +: HOLD_W]  = cfg.holdLen;
    rdData[LOCK_BIT]            = cfg.holdLock;
    rdData[PWAIT_LSB +: WAIT_W] = cfg.pageWait;
    rdData[PSEL_LSB +: PSEL_W]  = cfg.pageSel;
  end

  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe[2] && !effLock) |=> cfg.holdLen == $past(wrData[AP_LSB +: AP_W])); // R8
  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && wrBe[1]) && cfg.holdLock) |=> $stable(cfg.holdLen)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~RD_MASK) == 32'h0); // R1
endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int LONG_REST  = 5,
  parameter int SHORT_REST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              pageHit,
  input  logic [REST_W-1:0] restSel,
  input  logic [WAIT_W-1:0] waitLen,
  input  logic [WAIT_W-1:0] pageWait,
  input  logic [AP_W-1:0]   apLen,
  input  logic [HOLD_W-1:0] holdLen,
  input  logic [EQ_W-1:0]   eqLen,
  output logic              reqReady,
  output logic              respDone,
  output logic              flashEnN,
  output strobe_t           strb
);
  localparam int RC_W = $clog2(LONG_REST + 1);
  localparam logic [RC_W-1:0] RC_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_WAIT} state_t;

  state_t            state;
  logic [CYC_W-1:0]  cyc;
  logic [WAIT_W-1:0] waitCnt;
  logic [RC_W-1:0]   restCnt;
  logic [RC_W-1:0]   restNeed;
  logic [HALF_W-1:0] endHalf;
  logic [HALF_W-1:0] nextHalf;
  logic              lastCyc;
  logic              accept;

  always_comb begin
    endHalf  = halves(FIELD_MAX_W'(apLen)) + halves(FIELD_MAX_W'(holdLen)) + halves(eqLen);
    nextHalf = {cyc, 1'b0} + HALF_W'(2);
    lastCyc  = nextHalf >= endHalf;
    restNeed = (restSel == 2'b11) ? RC_W'(LONG_REST - 1) : RC_W'(SHORT_REST - 1);
    reqReady = (state == ST_IDLE) && (restCnt >= restNeed);
    accept   = reqValid && reqReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cyc      <= '0;
      waitCnt  <= '0;
      restCnt  <= RC_MAX;
      flashEnN <= 1'b1;
      respDone <= 1'b0;
    end else begin
      respDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            flashEnN <= 1'b0;
            cyc      <= '0;
            if (pageHit) begin
              state   <= ST_WAIT;
              waitCnt <= pageWait;
            end else begin
              state <= ST_PULSE;
            end
          end else if (restCnt != RC_MAX) begin
            restCnt <= restCnt + RC_W'(1);
          end
        end
        ST_PULSE: begin
          if (lastCyc) begin
            state   <= ST_WAIT;
            waitCnt <= waitLen;
          end else begin
            cyc <= cyc + CYC_W'(1);
          end
        end
        ST_WAIT: begin
          if (waitCnt == '0) begin
            state    <= ST_IDLE;
            flashEnN <= 1'b1;
            respDone <= 1'b1;
            restCnt  <= '0;
          end else begin
            waitCnt <= waitCnt - WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.accept  = accept;
    strb.capture = (state == ST_WAIT) && (waitCnt == '0);
    strb.inPulse = (state == ST_PULSE);
    strb.cyc     = cyc;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone); // R5
  AST_DONE_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> $rose(flashEnN)); // R5
  AST_READY_ONLY_REST: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> flashEnN); // R11
  AST_REST_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashEnN) |-> $past(flashEnN, 2)); // R10
endmodule

// File: rtl/flash_seq_dpath.sv
`timescale 1ns/1ps
module flash_seq_dpath
  import flash_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [AW-1:0]     reqAddr,
  input  logic [PSEL_W-1:0] pageSel,
  input  logic [AP_W-1:0]   apLen,
  input  logic [HOLD_W-1:0] holdLen,
  input  logic [EQ_W-1:0]   eqLen,
  input  logic [DW-1:0]     flashData,
  output logic              pageHit,
  output logic [AW-1:0]     flashAddr,
  output logic [DW-1:0]     respData,
  output logic              addrPulse,
  output logic              eqPulse
);
  localparam int NCH = 2;

  logic [AW-1:0]     lastAddr;
  logic              lastValid;
  logic [AW-1:0]     upperMask;
  logic [PSEL_W:0]   offBits;
  logic [HALF_W-1:0] winLo [NCH];
  logic [HALF_W-1:0] winHi [NCH];
  logic [HALF_W-1:0] h0, h1;
  logic [NCH-1:0]    chOut;

  always_comb begin
    offBits   = {1'b0, pageSel} + (PSEL_W+1)'(1);
    upperMask = {AW{1'b1}} << offBits;
    pageHit   = lastValid && (pageSel != '0) && (((reqAddr ^ lastAddr) & upperMask) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashAddr <= '0;
      lastAddr  <= '0;
      lastValid <= 1'b0;
      respData  <= '0;
    end else begin
      if (strb.accept) begin
        flashAddr <= reqAddr;
        lastAddr  <= reqAddr;
        lastValid <= 1'b1;
      end
      if (strb.capture) respData <= flashData;
    end
  end

  always_comb begin
    winLo[0] = '0;
    winHi[0] = halves(FIELD_MAX_W'(apLen));
    winLo[1] = winHi[0] + halves(FIELD_MAX_W'(holdLen));
    winHi[1] = winLo[1] + halves(eqLen);
    h0 = {strb.cyc, 1'b0};
    h1 = {strb.cyc, 1'b1};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wantA, wantB;
    logic pQ, bQ, nQ;
    assign wantA = strb.inPulse && (h0 >= winLo[g]) && (h0 < winHi[g]);
    assign wantB = strb.inPulse && (h1 >= winLo[g]) && (h1 < winHi[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pQ <= 1'b0;
        bQ <= 1'b0;
      end else begin
        pQ <= wantA ^ nQ;
        bQ <= wantB;
      end
    end
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) nQ <= 1'b0;
      else       nQ <= bQ ^ pQ;
    end
    assign chOut[g] = pQ ^ nQ;
  end

  assign addrPulse = chOut[0];
  assign eqPulse   = chOut[1];

  AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(addrPulse && eqPulse)); // R3
  AST_ADDR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(flashAddr)); // R11
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.inPulse) |-> (!addrPulse && !eqPulse)); // R6
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LONG_REST  = 5,
  parameter int SHORT_REST = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [3:0]    cfgWrBe,
  input  logic [31:0]   cfgWrData,
  output logic [31:0]   cfgRdData,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  output logic          respDone,
  output logic [DW-1:0] respData,
  output logic [AW-1:0] flashAddr,
  input  logic [DW-1:0] flashData,
  output logic          addrPulse,
  output logic          eqPulse,
  output logic          flashEnN
);
  cfg_t    cfg;
  strobe_t strb;
  logic    pageHit;

  flash_seq_cfg u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrBe(cfgWrBe),
    .wrData(cfgWrData), .cfg(cfg), .rdData(cfgRdData)
  );

  flash_seq_ctrl #(.LONG_REST(LONG_REST), .SHORT_REST(SHORT_REST)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pageHit(pageHit),
    .restSel(cfg.restSel), .waitLen(cfg.waitLen), .pageWait(cfg.pageWait),
    .apLen(cfg.apLen), .holdLen(cfg.holdLen), .eqLen(cfg.eqLen),
    .reqReady(reqReady), .respDone(respDone), .flashEnN(flashEnN), .strb(strb)
  );

  flash_seq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .pageSel(cfg.pageSel),
    .apLen(cfg.apLen), .holdLen(cfg.holdLen), .eqLen(cfg.eqLen),
    .flashData(flashData), .pageHit(pageHit), .flashAddr(flashAddr),
    .respData(respData), .addrPulse(addrPulse), .eqPulse(eqPulse)
  );
endmodule

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrBe = 4'h0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = 16'h0;
  logic        reqReady, respDone, addrPulse, eqPulse, flashEnN;
  logic [15:0] respData, flashAddr, flashData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign flashData = flashAddr ^ 16'h5A3C;

  flash_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrBe(cfgWrBe), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .respDone(respDone), .respData(respData), .flashAddr(flashAddr), .flashData(flashData),
    .addrPulse(addrPulse), .eqPulse(eqPulse), .flashEnN(flashEnN)
  );

  realtime tApRise, tApFall, tEqRise, tEqFall;
  int apRises = 0;
  int eqRises = 0;
  int doneCnt = 0;
  always @(posedge addrPulse) begin tApRise = $realtime; apRises++; end
  always @(negedge addrPulse) tApFall = $realtime;
  always @(posedge eqPulse) begin tEqRise = $realtime; eqRises++; end
  always @(negedge eqPulse) tEqFall = $realtime;
  always @(posedge clk) if (rstN && respDone) doneCnt++;

  typedef struct packed {
    logic [31:0] cfgWord;
    logic [31:0] rdWord;
    logic [15:0] addr;
    logic [7:0]  expAp;
    logic [7:0]  expGap;
    logic [7:0]  expEq;
    logic [7:0]  expLow;
    logic        hit;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h3F7F70F0, 32'h3F7F70F0, 16'h0100, 8'd8, 8'd8, 8'd16, 8'd32, 1'b0},
    '{32'h32000000, 32'h32000000, 16'h0104, 8'd1, 8'd1, 8'd1,  8'd5,  1'b0},
    '{32'h30240000, 32'h30242000, 16'h0200, 8'd3, 8'd3, 8'd5,  8'd7,  1'b0},
    '{32'h31135100, 32'h31135100, 16'h0300, 8'd2, 8'd6, 8'd4,  8'd8,  1'b0},
    '{32'h34370031, 32'h34373031, 16'h0400, 8'd4, 8'd4, 8'd8,  8'd13, 1'b0},
    '{32'h34370031, 32'h34373031, 16'h0403, 8'd0, 8'd0, 8'd0,  8'd4,  1'b1},
    '{32'h34370031, 32'h34373031, 16'h0404, 8'd4, 8'd4, 8'd8,  8'd13, 1'b0},
    '{32'h34370030, 32'h34373030, 16'h0404, 8'd4, 8'd4, 8'd8,  8'd13, 1'b0},
    '{32'h34370033, 32'h34373033, 16'h040F, 8'd0, 8'd0, 8'd0,  8'd4,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrBe = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrBe = 4'h0;
  endtask

  function automatic int halfCount(input realtime a, input realtime b);
    return $rtoi((b - a) / 4.0 + 0.5);
  endfunction

  task automatic doAccess(input logic [15:0] a, output int lowCyc,
                          output logic [15:0] dat, output logic doneSeen);
    realtime t0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = a; reqValid = 1'b1;
    @(negedge flashEnN);
    t0 = $realtime;
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge flashEnN);
    lowCyc = $rtoi(($realtime - t0) / 8.0 + 0.5);
    @(negedge clk);
    dat = respData;
    doneSeen = respDone;
  endtask

  task automatic restRun(input logic [31:0] word, input int expHigh, input string tag);
    realtime t1;
    int hiCyc;
    cfgWrite(4'hF, word);
    repeat (8) @(negedge clk);
    reqAddr = 16'h0800; reqValid = 1'b1;
    @(negedge flashEnN);
    @(posedge flashEnN);
    t1 = $realtime;
    @(negedge flashEnN);
    hiCyc = $rtoi(($realtime - t1) / 8.0 + 0.5);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge flashEnN);
    chk(hiCyc == expHigh, tag, hiCyc, expHigh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lowCyc;
    logic [15:0] dat;
    logic doneSeen;
    int ap0, eq0, dc0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfgRdData == 32'h3F7F70F0, "R1 reset config", cfgRdData, 32'h3F7F70F0);
    chk(flashEnN == 1'b1 && addrPulse == 1'b0 && eqPulse == 1'b0 && respDone == 1'b0,
        "R1 reset strobes", {flashEnN, addrPulse, eqPulse, respDone}, 4'b1000);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);

    // Table walk: R2 R3 R4 R5 R6 R7 R12 plus link rules R8 R9
    for (int i = 0; i < NV; i++) begin
      cfgWrite(4'hF, VECS[i].cfgWord);
      chk(cfgRdData == VECS[i].rdWord, (i == 3) ? "R9 locked hold readback" : "R8 hold link readback",
          cfgRdData, VECS[i].rdWord);
      ap0 = apRises; eq0 = eqRises;
      doAccess(VECS[i].addr, lowCyc, dat, doneSeen);
      chk(lowCyc == int'(VECS[i].expLow),
          VECS[i].hit ? ((i == 8) ? "R12 hit access length" : "R6 hit access length")
                      : ((i == 7) ? "R7 no hit with page select 0" : "R5 access length"),
          lowCyc, VECS[i].expLow);
      chk(doneSeen == 1'b1 && dat == (VECS[i].addr ^ 16'h5A3C), "R5 done and data",
          dat, VECS[i].addr ^ 16'h5A3C);
      @(negedge clk);
      chk(respDone == 1'b0, "R5 done single cycle", respDone, 0);
      if (VECS[i].hit) begin
        chk(apRises == ap0 && eqRises == eq0, "R6 no pulses on hit",
            (apRises - ap0) + (eqRises - eq0), 0);
      end else begin
        chk(apRises == ap0 + 1 && eqRises == eq0 + 1, "R2 one pulse each",
            (apRises - ap0) * 16 + (eqRises - eq0), 17);
        chk(halfCount(tApRise, tApFall) == int'(VECS[i].expAp), "R2 address pulse width",
            halfCount(tApRise, tApFall), VECS[i].expAp);
        chk(halfCount(tApFall, tEqRise) == int'(VECS[i].expGap), "R3 hold gap",
            halfCount(tApFall, tEqRise), VECS[i].expGap);
        chk(halfCount(tEqRise, tEqFall) == int'(VECS[i].expEq), "R4 equalise width",
            halfCount(tEqRise, tEqFall), VECS[i].expEq);
      end
    end

    // R1 reserved bits read zero
    cfgWrite(4'hF, 32'hFFFF_FFFF);
    chk(cfgRdData == 32'h3F7F71F7, "R1 reserved bits", cfgRdData, 32'h3F7F71F7);

    // R8 / R9 byte-lane link of the hold field
    cfgWrite(4'hF, 32'h3000_0000);
    cfgWrite(4'b0100, 32'h0053_0000);
    chk(cfgRdData == 32'h3053_5000, "R8 lane 2 copies hold", cfgRdData, 32'h3053_5000);
    cfgWrite(4'b0010, 32'h0000_2000);
    chk(cfgRdData == 32'h3053_2000, "R9 explicit hold write", cfgRdData, 32'h3053_2000);
    cfgWrite(4'b0100, 32'h0061_0000);
    chk(cfgRdData == 32'h3061_6000, "R8 copy after explicit", cfgRdData, 32'h3061_6000);
    cfgWrite(4'b0010, 32'h0000_0100);
    cfgWrite(4'b0100, 32'h0020_0000);
    chk(cfgRdData == 32'h3020_0100, "R9 lock keeps hold", cfgRdData, 32'h3020_0100);

    // R10 rest time between back-to-back accesses
    restRun(32'h3000_0000, 5, "R10 long rest");
    restRun(32'h1000_0000, 2, "R10 short rest sel 1");
    restRun(32'h0000_0000, 2, "R10 short rest sel 0");

    // R11 requests while busy are ignored
    cfgWrite(4'hF, 32'h3F7F70F0);
    repeat (8) @(negedge clk);
    dc0 = doneCnt;
    reqAddr = 16'h0A00; reqValid = 1'b1;
    @(negedge flashEnN);
    @(negedge clk);
    reqAddr = 16'h0B00;
    for (int k = 0; k < 10; k++) begin
      if (k == 0 || k == 9)
        chk(reqReady == 1'b0 && flashAddr == 16'h0A00, "R11 busy holds off",
            {reqReady, flashAddr}, {1'b0, 16'h0A00});
      @(negedge clk);
    end
    reqValid = 1'b0;
    @(posedge flashEnN);
    @(negedge clk);
    chk(respData == (16'h0A00 ^ 16'h5A3C), "R11 data from first request",
        respData, 16'h0A00 ^ 16'h5A3C);
    repeat (12) @(negedge clk);
    chk(doneCnt == dc0 + 1 && flashAddr == 16'h0A00, "R11 single access",
        doneCnt - dc0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule